// File: doc/BRIEF.md
# Idle/Standby Power Management Controller

This block holds one 32-bit configuration word for a bus peripheral that has both a slave port and a master port. It turns that word into the peripheral's power-management handshakes. On the slave side it answers the power manager's idle request with an idle acknowledge, following one of three policies: forced, never, or smart. Under the smart policy the acknowledge waits until the peripheral is quiet. On the master side it drives a standby output under the same three policies, with the smart policy following master-port activity.

The block also produces a clock-gate enable that follows interconnect activity when auto clock gating is on. It raises a wakeup request when the peripheral is idle-acknowledged, the smart idle policy is selected and wakeup is enabled. Writing the soft reset bit starts a self-timed reset window. During that window the busy output is high, the other fields return to their reset values, and register writes are refused.

Software reaches the word through a simple strobe/address/data port with registered read data.

Top module: `pm_cfg_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x0000_0001 (auto-idle set, all else zero), standby_o is 1, idle_ack_o, wake_req_o and srst_busy_o are 0.
- R2: Field positions are auto-idle bit 0, soft reset bit 1, wakeup enable bit 2, idle mode bits 4:3 and standby mode bits 13:12. All other bits are dropped on write and read as 0. Read data appears on reg_rdata_o the cycle after the read strobe. A write or read at any address other than CFG_ADDR has no effect on the word and reads 0.
- R3: With idle mode 0 (forced), idle_ack_o rises the cycle after idle_req_i is seen high, whatever the peripheral activity.
- R4: With idle mode 1 or 3 (never), idle_ack_o stays 0 while idle_req_i is high.
- R5: With idle mode 2 (smart), idle_ack_o rises only after a cycle in which idle_req_i is high and slv_busy_i is low. Activity before the acknowledge holds it off. Activity after the acknowledge does not remove it.
- R6: In every mode, idle_ack_o is 0 the cycle after idle_req_i is seen low.
- R7: standby_o is registered and follows the standby mode one cycle later: mode 0 gives 1, modes 1 and 3 give 0, and mode 2 gives the inverse of mst_busy_i.
- R8: clk_en_o is 1 when ic_active_i is 1, when auto-idle is 0, or during a soft reset. Otherwise it is 0.
- R9: Writing 1 to bit 1 raises srst_busy_o from the next cycle for exactly SRST_CYCLES cycles (default 8). During that window the word reads with bit 1 set and every other field at its reset value. Afterwards bit 1 reads 0.
- R10: Register writes while srst_busy_o is high are ignored.
- R11: With idle mode 2, wakeup enable 1 and idle_ack_o high, a wake_evt_i pulse raises wake_req_o the next cycle. It stays high until the cycle after idle_req_i drops. With wakeup enable 0 it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| idle_req_i | input | 1 | Idle request from power manager |
| slv_busy_i | input | 1 | Peripheral has pending activity |
| idle_ack_o | output | 1 | Idle acknowledge |
| wake_evt_i | input | 1 | Wakeup event from peripheral |
| wake_req_o | output | 1 | Wakeup request to power manager |
| mst_busy_i | input | 1 | Master port has pending activity |
| standby_o | output | 1 | Master standby indication |
| ic_active_i | input | 1 | Interconnect activity |
| clk_en_o | output | 1 | Interface clock-gate enable |
| srst_busy_o | output | 1 | Soft reset in progress |

## Verification
The hardest situation to reach is a write that arrives inside the soft reset window. The bench starts a soft reset and issues a read while the counter is still running, which catches the busy bit set and the fields cleared. It then writes a new idle mode two cycles later and checks after the window that the word still holds its reset value. Smart idle hold-off is reached by raising the idle request while activity is present and then releasing the activity. After the acknowledge, activity is raised again to show that the acknowledge stays.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;
  localparam int DATA_W    = 32;
  localparam int AIDLE_BIT = 0;
  localparam int SRST_BIT  = 1;
  localparam int WKEN_BIT  = 2;
  localparam int IDLE_LSB  = 3;
  localparam int STBY_LSB  = 12;

  typedef enum logic [1:0] {
    MODE_FORCE = 2'd0,
    MODE_NONE  = 2'd1,
    MODE_SMART = 2'd2,
    MODE_RSVD  = 2'd3
  } pm_mode_e;

  typedef struct packed {
    pm_mode_e stby;
    pm_mode_e idle;
    logic     wken;
    logic     srst;
    logic     aidle;
  } pm_cfg_t;

  localparam pm_cfg_t CFG_RST = '{stby: MODE_FORCE, idle: MODE_FORCE,
                                  wken: 1'b0, srst: 1'b0, aidle: 1'b1};

  function automatic logic [DATA_W-1:0] pack_cfg(pm_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[AIDLE_BIT]             = c.aidle;
    w[SRST_BIT]              = c.srst;
    w[WKEN_BIT]              = c.wken;
    w[IDLE_LSB+1:IDLE_LSB]   = c.idle;
    w[STBY_LSB+1:STBY_LSB]   = c.stby;
    return w;
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_cfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CFG_ADDR    = 0,
  parameter int SRST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output pm_cfg_t           cfg_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES);

  pm_cfg_t          cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit, wr_ok;

  assign hit    = (addr_i == ADDR_W'(CFG_ADDR));
  assign busy_o = (cnt_q != '0);
  assign wr_ok  = wr_i && hit && !busy_o;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:STBY_LSB+2], wdata_i[STBY_LSB-1:IDLE_LSB+2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      cnt_q <= '0;
    end else if (wr_ok && wdata_i[SRST_BIT]) begin
      cfg_q <= CFG_RST;      // soft reset overrides the written fields
      cnt_q <= CNT_LOAD;
    end else begin
      if (busy_o) cnt_q <= cnt_q - 1'b1;
      if (wr_ok) begin
        cfg_q.aidle <= wdata_i[AIDLE_BIT];
        cfg_q.wken  <= wdata_i[WKEN_BIT];
        cfg_q.idle  <= pm_mode_e'(wdata_i[IDLE_LSB+1:IDLE_LSB]);
        cfg_q.stby  <= pm_mode_e'(wdata_i[STBY_LSB+1:STBY_LSB]);
      end
    end
  end

  always_comb begin
    cfg_o      = cfg_q;
    cfg_o.srst = busy_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdata_o <= '0;
    else if (rd_i && hit) rdata_o <= pack_cfg(cfg_o);
    else                  rdata_o <= '0;
  end

  AST_SRST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);                                                   // R9
  AST_SRST_FIELDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cfg_q == CFG_RST));                                       // R9
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != CNT_LOAD) |=> $stable(cfg_q));                    // R10
endmodule

// File: rtl/pm_idle_hs.sv
module pm_idle_hs
  import pm_cfg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pm_mode_e mode_i,
  input  logic     wken_i,
  input  logic     req_i,
  input  logic     busy_i,
  input  logic     wake_evt_i,
  output logic     ack_o,
  output logic     wake_o
);
  logic ack_d, wake_d, smart;

  assign smart = (mode_i == MODE_SMART);

  always_comb begin
    unique case (mode_i)
      MODE_FORCE: ack_d = req_i;
      MODE_SMART: ack_d = req_i && (ack_o || !busy_i);  // hold once granted
      default:    ack_d = 1'b0;
    endcase
    wake_d = req_i && smart && wken_i && (wake_o || (ack_o && wake_evt_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      ack_o  <= ack_d;
      wake_o <= wake_d;
    end
  end

  AST_ACK_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NONE || mode_i == MODE_RSVD) |=> !ack_o);            // R4
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);                                                   // R6
  AST_SMART_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smart && !ack_o && busy_i) |=> !ack_o);                              // R5
  AST_WAKE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || !wken_i) |=> !wake_o);                                     // R11
endmodule

// File: rtl/pm_mst_pm.sv
module pm_mst_pm
  import pm_cfg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pm_mode_e mode_i,
  input  logic     mst_busy_i,
  input  logic     aidle_i,
  input  logic     ic_active_i,
  input  logic     srst_busy_i,
  output logic     standby_o,
  output logic     clk_en_o
);
  logic stby_d;

  always_comb begin
    unique case (mode_i)
      MODE_FORCE: stby_d = 1'b1;
      MODE_SMART: stby_d = !mst_busy_i;
      default:    stby_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) standby_o <= 1'b1;  // reset mode is forced standby
    else         standby_o <= stby_d;
  end

  assign clk_en_o = ic_active_i || !aidle_i || srst_busy_i;

  AST_STBY_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NONE || mode_i == MODE_RSVD) |=> !standby_o);         // R7
  AST_STBY_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FORCE) |=> standby_o);                                // R7
  AST_STBY_SMART_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SMART && mst_busy_i) |=> !standby_o);                 // R7
endmodule

// File: rtl/pm_cfg_ctrl.sv
module pm_cfg_ctrl
  import pm_cfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CFG_ADDR    = 0,
  parameter int SRST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              idle_req_i,
  input  logic              slv_busy_i,
  output logic              idle_ack_o,
  input  logic              wake_evt_i,
  output logic              wake_req_o,
  input  logic              mst_busy_i,
  output logic              standby_o,
  input  logic              ic_active_i,
  output logic              clk_en_o,
  output logic              srst_busy_o
);
  pm_cfg_t cfg;

  pm_cfg_regs #(
    .ADDR_W     (ADDR_W),
    .CFG_ADDR   (CFG_ADDR),
    .SRST_CYCLES(SRST_CYCLES)
  ) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg),
    .busy_o (srst_busy_o)
  );

  pm_idle_hs i_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (cfg.idle),
    .wken_i    (cfg.wken),
    .req_i     (idle_req_i),
    .busy_i    (slv_busy_i),
    .wake_evt_i(wake_evt_i),
    .ack_o     (idle_ack_o),
    .wake_o    (wake_req_o)
  );

  pm_mst_pm i_mst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (cfg.stby),
    .mst_busy_i (mst_busy_i),
    .aidle_i    (cfg.aidle),
    .ic_active_i(ic_active_i),
    .srst_busy_i(srst_busy_o),
    .standby_o  (standby_o),
    .clk_en_o   (clk_en_o)
  );

  AST_GATE_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o) |-> (!ic_active_i && !srst_busy_o));                      // R8
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ack_o |-> $past(idle_req_i));                                    // R3
endmodule

// File: tb/test_pm_cfg_ctrl.sv
module test_pm_cfg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 0, rd = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        idle_req = 0, slv_busy = 0, ack, wake_evt = 0, wake_req;
  logic        mst_busy = 0, stby, ic_active = 0, clk_en, srst_busy;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  pm_cfg_ctrl i_pm_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .idle_req_i(idle_req), .slv_busy_i(slv_busy), .idle_ack_o(ack),
    .wake_evt_i(wake_evt), .wake_req_o(wake_req), .mst_busy_i(mst_busy),
    .standby_o(stby), .ic_active_i(ic_active), .clk_en_o(clk_en),
    .srst_busy_o(srst_busy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [31:0] d, logic [3:0] a = 4'd0);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = '0;
  endtask

  task automatic rd_chk(string req, logic [31:0] exp, logic [3:0] a = 4'd0);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; addr = '0;
    check(req, rdata, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 standby", stby, 1);
    check("R1 ack", ack, 0);
    check("R1 wake", wake_req, 0);
    check("R1 busy", srst_busy, 0);
    rd_chk("R1 word", 32'h1);
  endtask

  task automatic t_layout;
    wr_cfg(32'hFFFF_FFFD);
    rd_chk("R2 reserved dropped", 32'h0000_301D);
    wr_cfg(32'h0, 4'd1);
    rd_chk("R2 other addr write ignored", 32'h0000_301D);
    rd_chk("R2 other addr reads zero", 32'h0, 4'd2);
  endtask

  task automatic t_clk_en;
    wr_cfg(32'h1);
    ic_active = 0; cyc(1);
    check("R8 gated", clk_en, 0);
    ic_active = 1; cyc(1);
    check("R8 active", clk_en, 1);
    ic_active = 0;
    wr_cfg(32'h0);
    check("R8 autoidle off", clk_en, 1);
    wr_cfg(32'h1);
  endtask

  task automatic t_force_idle;
    wr_cfg(32'h1);
    slv_busy = 1;
    @(negedge clk); idle_req = 1;
    #1 check("R3 not yet", ack, 0);
    cyc(1);
    check("R3 forced ack", ack, 1);
    idle_req = 0; cyc(1);
    check("R6 drop", ack, 0);
    slv_busy = 0;
  endtask

  task automatic t_no_idle;
    wr_cfg(32'h09);
    idle_req = 1; cyc(3);
    check("R4 mode1", ack, 0);
    idle_req = 0;
    wr_cfg(32'h19);
    idle_req = 1; cyc(3);
    check("R4 mode3", ack, 0);
    idle_req = 0; cyc(1);
  endtask

  task automatic t_smart_idle;
    wr_cfg(32'h11);
    slv_busy = 1; idle_req = 1; cyc(3);
    check("R5 holdoff", ack, 0);
    slv_busy = 0; cyc(1);
    check("R5 grant", ack, 1);
    slv_busy = 1; cyc(2);
    check("R5 hold", ack, 1);
    idle_req = 0; cyc(1);
    check("R6 smart drop", ack, 0);
    slv_busy = 0;
  endtask

  task automatic t_wake;
    wr_cfg(32'h15);
    idle_req = 1; cyc(1);
    check("R11 ack", ack, 1);
    wake_evt = 1; cyc(1);
    wake_evt = 0;
    check("R11 wake rise", wake_req, 1);
    cyc(2);
    check("R11 wake hold", wake_req, 1);
    idle_req = 0; cyc(1);
    check("R11 wake drop", wake_req, 0);
    wr_cfg(32'h11);
    idle_req = 1; cyc(1);
    wake_evt = 1; cyc(1);
    wake_evt = 0;
    check("R11 wken off", wake_req, 0);
    idle_req = 0; cyc(1);
  endtask

  task automatic t_standby;
    wr_cfg(32'h1001); cyc(1);
    check("R7 never", stby, 0);
    mst_busy = 1;
    wr_cfg(32'h2001); cyc(1);
    check("R7 smart busy", stby, 0);
    mst_busy = 0; cyc(1);
    check("R7 smart idle", stby, 1);
    wr_cfg(32'h3001); cyc(1);
    check("R7 mode3", stby, 0);
    wr_cfg(32'h0001); cyc(1);
    check("R7 force", stby, 1);
  endtask

  task automatic t_srst_len;
    int n = 0;
    wr_cfg(32'h1017);
    for (int i = 0; i < 12; i++) begin
      if (srst_busy) n++;
      @(negedge clk);
    end
    check("R9 window length", n, 8);
    rd_chk("R9 fields reset", 32'h1);
  endtask

  task automatic t_srst_write;
    wr_cfg(32'h1016);
    check("R8 clk_en in srst", clk_en, 1);
    rd_chk("R9 busy readback", 32'h3);
    wr_cfg(32'h10);
    cyc(10);
    check("R9 busy clear", srst_busy, 0);
    rd_chk("R10 write ignored", 32'h1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_layout();
    t_clk_en();
    t_force_idle();
    t_no_idle();
    t_smart_idle();
    t_wake();
    t_standby();
    t_srst_len();
    t_srst_write();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule